// File: doc/BRIEF.md
# Subranging Converter Pass Sequencer

This block is the timing brain of a three-pass subranging analog-to-digital converter. A single fast clock drives it. A start request is sampled like the data input of a flip-flop. Each accepted request then plays out a fixed 20-clock schedule:

- the track/hold is put into hold;
- the flash converter is strobed three times, with settling gaps between the strobes;
- the first two flash codes are loaded into the reference DAC;
- the error-amplifier routing is switched between passes;
- the track/hold is released to track before the frame ends;
- a done pulse closes the frame.

Analog settling is represented only by clock counts. The digital correction of the three codes is left to downstream logic. The block simply presents the three captured codes.

A start request that arrives while a frame is running is discarded. The exception is a request seen on the final cycle of a frame, which chains straight into the next frame with no idle cycle. Holding start high therefore gives free-running conversion at one twentieth of the clock rate.

Top module: `subrange_seq`

## Requirements
- R1: While `rst_i` is high at a clock edge, the block becomes idle after that edge. In the idle state `hold_o`=0, `strobe_o`=0, both DAC load pulses are 0, `route_o`=0, `done_o`=0, and all three pass codes read 0.
- R2: A frame begins at a rising edge where `start_i` is high and the block is idle. Counting the cycle after that edge as frame cycle 0, `hold_o` is high for cycles 0 through 12 and low from cycle 13 on.
- R3: `strobe_o` bit 0 is high only in frame cycle 1, bit 1 only in cycle 6, and bit 2 only in cycle 12. Each strobe is one clock long.
- R4: At the edge that ends a strobe cycle, `flash_i` is captured into the matching pass code: bit 0 into `pass1_o`, bit 1 into `pass2_o`, bit 2 into `pass3_o`. Each code holds its value until that same strobe fires again.
- R5: `dac_ld_msb_o` pulses in frame cycle 2, and `dac_ld_lsb_o` pulses in cycle 7. Each pulse lasts one clock. The DAC takes its data from `pass1_o` and `pass2_o` respectively.
- R6: `route_o` selects the flash input path. Code 0 is the attenuated direct path, used when idle and in frame cycles 0–1 and 13–19. Code 1 is the first error amplifier, used in cycles 2–6. Code 2 is both amplifiers cascaded, used in cycles 7–12.
- R7: `done_o` is high for exactly one clock, in frame cycle 19.
- R8: `start_i` has no effect at the edges that end frame cycles 0 through 18.
- R9: If `start_i` is high at the edge ending frame cycle 19, a new frame cycle 0 follows immediately. With `start_i` held high, `hold_o` rises every 20 clocks.
- R10: If `start_i` is low at the edge ending frame cycle 19, the block returns to idle and stays there until a new start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-convert request, sampled at each rising edge |
| flash_i | input | 8 | Output code of the flash converter |
| hold_o | output | 1 | Track/hold command, 1 = hold |
| strobe_o | output | 3 | Flash strobes for passes 1..3 (bit 0 = pass 1) |
| dac_ld_msb_o | output | 1 | Load pulse for the reference DAC upper bits |
| dac_ld_lsb_o | output | 1 | Load pulse for the reference DAC refinement |
| route_o | output | 2 | Error-amplifier path select (0 attenuate, 1 one amp, 2 cascade) |
| done_o | output | 1 | Frame complete pulse |
| pass1_o | output | 8 | Captured pass-1 code |
| pass2_o | output | 8 | Captured pass-2 code |
| pass3_o | output | 8 | Captured pass-3 code |

## Verification
A behavioural frame-phase model is compared against every output on every clock.

- A lone one-cycle start shows the absolute position of each event within the frame.
- Start pokes placed in cycles 5, 12 and 18 of a running frame separate a design that discards mid-frame requests from one that restarts or queues them.
- Start held high for many frames shows the gapless 20-clock period.
- A start asserted only on cycle 19 isolates the chaining edge from the general rejection rule.

The flash bus changes value every clock, so capturing on the wrong cycle shows up as a wrong code.

// File: rtl/subrange_seq_pkg.sv
package subrange_seq_pkg;

    // Flash path routing choices
    typedef enum logic [1:0] {
        RT_ATTEN   = 2'd0,
        RT_AMP1    = 2'd1,
        RT_CASCADE = 2'd2
    } route_t;

    // Default schedule (frame cycle numbers)
    localparam int FRAME_LEN_D = 20;
    localparam int STB1_AT_D   = 1;
    localparam int LDMSB_AT_D  = 2;
    localparam int STB2_AT_D   = 6;
    localparam int LDLSB_AT_D  = 7;
    localparam int STB3_AT_D   = 12;
    localparam int REL_AT_D    = 13;
    localparam int NPASS       = 3;

    // Decoded control bundle for one cycle
    typedef struct packed {
        logic              hold;
        logic [NPASS-1:0]  strobe;
        logic              ld_msb;
        logic              ld_lsb;
        route_t            route;
        logic              done;
    } seq_evt_t;

    // True when cnt lies in the half-open window [lo, hi)
    function automatic logic in_win(input int cnt, input int lo, input int hi);
        return (cnt >= lo) && (cnt < hi);
    endfunction

endpackage

// File: rtl/sr_cycle_ctr.sv
module sr_cycle_ctr #(
    parameter int FRAME_LEN = 20,
    localparam int CW = $clog2(FRAME_LEN)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign last_o = busy_q && (cnt_q == CW'(FRAME_LEN - 1));
    // a request counts only when idle or on the closing cycle
    assign accept = start_i && (!busy_q || last_o);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (last_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign busy_o = busy_q;
    assign cnt_o  = cnt_q;

    // R8
    cnt_adv_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
    // R9
    chain_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (last_o && start_i) |=> (busy_q && cnt_q == '0));
    // R10
    idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (last_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/sr_event_dec.sv
module sr_event_dec
    import subrange_seq_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_LEN_D,
    parameter int STB1_AT   = STB1_AT_D,
    parameter int STB2_AT   = STB2_AT_D,
    parameter int STB3_AT   = STB3_AT_D,
    parameter int LDMSB_AT  = LDMSB_AT_D,
    parameter int LDLSB_AT  = LDLSB_AT_D,
    parameter int REL_AT    = REL_AT_D,
    localparam int CW = $clog2(FRAME_LEN)
) (
    input  logic          busy_i,
    input  logic [CW-1:0] cnt_i,
    output seq_evt_t      evt_o
);
    localparam int STB_AT [NPASS] = '{STB1_AT, STB2_AT, STB3_AT};

    int c;
    assign c = int'(cnt_i);

    for (genvar i = 0; i < NPASS; i++) begin : g_stb
        assign evt_o.strobe[i] = busy_i && (c == STB_AT[i]);
    end

    always_comb begin
        evt_o.hold   = busy_i && in_win(c, 0, REL_AT);
        evt_o.ld_msb = busy_i && (c == LDMSB_AT);
        evt_o.ld_lsb = busy_i && (c == LDLSB_AT);
        evt_o.done   = busy_i && (c == FRAME_LEN - 1);
        evt_o.route  = RT_ATTEN;
        if (busy_i && in_win(c, LDMSB_AT, LDLSB_AT))
            evt_o.route = RT_AMP1;
        else if (busy_i && in_win(c, LDLSB_AT, REL_AT))
            evt_o.route = RT_CASCADE;
    end
endmodule

// File: rtl/sr_pass_capture.sv
module sr_pass_capture
    import subrange_seq_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NPASS-1:0]     strobe_i,
    input  logic [FW-1:0]        flash_i,
    output logic [NPASS*FW-1:0]  pass_o
);
    for (genvar i = 0; i < NPASS; i++) begin : g_cap
        logic [FW-1:0] code_q;
        always_ff @(posedge clk_i) begin
            if (rst_i)            code_q <= '0;
            else if (strobe_i[i]) code_q <= flash_i;
        end
        assign pass_o[i*FW +: FW] = code_q;

        // R4
        passcap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            strobe_i[i] |=> (code_q == $past(flash_i)));
    end
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
    import subrange_seq_pkg::*;
#(
    parameter int FW        = 8,
    parameter int FRAME_LEN = FRAME_LEN_D,
    localparam int CW = $clog2(FRAME_LEN)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [FW-1:0] flash_i,
    output logic          hold_o,
    output logic [2:0]    strobe_o,
    output logic          dac_ld_msb_o,
    output logic          dac_ld_lsb_o,
    output logic [1:0]    route_o,
    output logic          done_o,
    output logic [FW-1:0] pass1_o,
    output logic [FW-1:0] pass2_o,
    output logic [FW-1:0] pass3_o
);
    logic                busy;
    logic [CW-1:0]       cnt;
    logic                last;
    seq_evt_t            evt;
    logic [NPASS*FW-1:0] passes;

    sr_cycle_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
        .busy_o(busy), .cnt_o(cnt), .last_o(last)
    );

    sr_event_dec #(.FRAME_LEN(FRAME_LEN)) u_dec (
        .busy_i(busy), .cnt_i(cnt), .evt_o(evt)
    );

    sr_pass_capture #(.FW(FW)) u_cap (
        .clk_i(clk_i), .rst_i(rst_i), .strobe_i(evt.strobe),
        .flash_i(flash_i), .pass_o(passes)
    );

    assign hold_o       = evt.hold;
    assign strobe_o     = evt.strobe;
    assign dac_ld_msb_o = evt.ld_msb;
    assign dac_ld_lsb_o = evt.ld_lsb;
    assign route_o      = evt.route;
    assign done_o       = evt.done;
    assign pass1_o      = passes[0*FW +: FW];
    assign pass2_o      = passes[1*FW +: FW];
    assign pass3_o      = passes[2*FW +: FW];

    // R2
    hold_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hold_o) |-> $past(start_i));
    // R3
    strobe_in_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|strobe_o) |-> hold_o);
    // R7
    done_tracking_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!hold_o && route_o == 2'd0));
    // R5
    evt_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({strobe_o, dac_ld_msb_o, dac_ld_lsb_o, done_o}));
    // R6
    third_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o[2] |-> (route_o == 2'd2));
    // R1
    reset_idle_chk: assert property (@(posedge clk_i)
        rst_i |=> (!hold_o && strobe_o == '0 && !done_o));
endmodule

// File: tb/subrange_seq_tb_top.sv
module subrange_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] flash_i = 8'h00;
    logic       hold_o, dac_ld_msb_o, dac_ld_lsb_o, done_o;
    logic [2:0] strobe_o;
    logic [1:0] route_o;
    logic [7:0] pass1_o, pass2_o, pass3_o;

    int n_chk = 0;
    int n_bad = 0;
    int phase = -1;          // -1 idle, else frame cycle
    int exp_p [3] = '{0, 0, 0};
    int rises = 0;
    logic prev_hold = 1'b0;
    bit finished = 0;

    always #5 clk = ~clk;

    subrange_seq dut_i (
        .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .flash_i(flash_i),
        .hold_o(hold_o), .strobe_o(strobe_o), .dac_ld_msb_o(dac_ld_msb_o),
        .dac_ld_lsb_o(dac_ld_lsb_o), .route_o(route_o), .done_o(done_o),
        .pass1_o(pass1_o), .pass2_o(pass2_o), .pass3_o(pass3_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst_i) begin
            phase = -1;
            exp_p = '{0, 0, 0};
        end else begin
            if (phase == 1)  exp_p[0] = int'(flash_i);
            if (phase == 6)  exp_p[1] = int'(flash_i);
            if (phase == 12) exp_p[2] = int'(flash_i);
            if ((phase == -1 || phase == 19) && start_i) phase = 0;
            else if (phase >= 0 && phase < 19)            phase = phase + 1;
            else                                          phase = -1;
        end
    end

    // compare every cycle, away from the active edge; flash changes each cycle
    always @(negedge clk) begin
        int er;
        er = (phase >= 2 && phase <= 6) ? 1 : (phase >= 7 && phase <= 12) ? 2 : 0;
        chk("R1/R2/R8/R9/R10 hold", int'(hold_o), int'(phase >= 0 && phase <= 12));
        chk("R3 strobe", int'(strobe_o),
            (phase == 1) ? 1 : (phase == 6) ? 2 : (phase == 12) ? 4 : 0);
        chk("R5 dac msb load", int'(dac_ld_msb_o), int'(phase == 2));
        chk("R5 dac lsb load", int'(dac_ld_lsb_o), int'(phase == 7));
        chk("R6 route", int'(route_o), er);
        chk("R7 done", int'(done_o), int'(phase == 19));
        chk("R4 pass1", int'(pass1_o), exp_p[0]);
        chk("R4 pass2", int'(pass2_o), exp_p[1]);
        chk("R4 pass3", int'(pass3_o), exp_p[2]);
        if (hold_o && !prev_hold) rises++;
        prev_hold = hold_o;
        flash_i <= flash_i + 8'd37;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst_i = 1'b0;
        cyc(5);
        // single shot
        start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(25);
        // mid-frame pokes at cycles 5, 12, 18
        rises = 0;
        start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(5);  start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(6);  start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(5);  start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(10);
        chk("R8 mid-frame starts rejected", rises, 1);
        chk("R10 idle after frame", int'(hold_o), 0);
        // free running
        rises = 0;
        start_i = 1'b1; cyc(100); start_i = 1'b0;
        cyc(25);
        chk("R9 free-run frame count", rises, 5);
        // start only on closing cycle
        rises = 0;
        start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(19); start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(30);
        chk("R9 chained on cycle 19", rises, 2);
        // reset mid-frame
        start_i = 1'b1; cyc(1); start_i = 1'b0;
        cyc(8); rst_i = 1'b1; cyc(2); rst_i = 1'b0;
        chk("R1 reset clears pass1", int'(pass1_o), 0);
        cyc(10);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule